// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for each incoming frame, whether the frame should be kept. It examines the first six bytes of the frame (the destination address) and compares them against a programmed station address. It also checks them against the all-ones broadcast address, and against a 64-bin multicast hash table indexed by part of a CRC-32 over the destination. A registered address verdict is produced one cycle after the sixth byte. A registered frame verdict follows one cycle after the last byte of the frame. At that point the frame length and the externally computed CRC/alignment error flag are also taken into account.

Configuration inputs control broadcast acceptance, hashed multicast acceptance, promiscuous unicast acceptance, acceptance of short frames, acceptance of errored frames and a monitor mode. In monitor mode an accepted frame is flagged as missed instead of being stored. With the remote transmitter control enabled, a multicast destination that hashes to one of the two top bins produces a one-cycle pulse that turns the local transmitter off or on.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, addrDone, addrHit, addrGroup, frameDone, frameStore, frameMissed, txOff and txOn are all 0.
- R2: Destination byte i (i = 0 first received) is compared with stationAddr[8i+7:8i]. A destination with bit 0 of byte 0 clear is unicast. With cfgPromisc low, a unicast destination hits only when all six bytes equal the station address. addrDone pulses for one cycle, in the cycle after the sixth accepted byte, with addrHit giving the result and addrGroup = 0. addrHit and addrGroup hold until the next frame start, which clears them to 0.
- R3: With cfgPromisc high, every unicast destination hits, with addrGroup = 0.
- R4: A destination of all 48 bits set is broadcast. It hits exactly when cfgAcceptBcast is high, and addrGroup = 1.
- R5: A destination with bit 0 of byte 0 set that is not broadcast is multicast. Its hash index is bits 31:26 of a CRC register computed as follows. The register starts at all ones. The 48 destination bits are then fed in order, byte 0 first and each byte LSB first. For each bit, feedback = reg[0] XOR bit, the register shifts right one place, and it is XORed with 32'hEDB88320 when feedback is 1. No final inversion is applied. The frame hits exactly when cfgAcceptMcast is high and hashTable[index] is 1, and addrGroup = 1.
- R6: frameDone pulses for one cycle in the cycle after the byte marked inLast. The frame length counts every accepted byte from the start byte to the last byte inclusive. A frame shorter than 64 bytes is rejected unless cfgAcceptRunt is high. A frame of fewer than six bytes is always rejected.
- R7: inBadCrc is sampled only with the last byte of a frame. When it is high the frame is rejected unless cfgSaveBad is high.
- R8: A frame passing all checks gives frameStore = 1 in the frameDone cycle when cfgMonitor is low. When cfgMonitor is high it gives frameMissed = 1 and frameStore = 0. Both outputs are 0 outside the frameDone cycle and for rejected frames.
- R9: With cfgAutoTx high, a multicast (non-broadcast) destination with hash index 62 pulses txOff, and one with index 63 pulses txOn. The pulse falls in the addrDone cycle, regardless of cfgAcceptMcast and the hash table. With cfgAutoTx low neither pulses.
- R10: Cycles with inValid low have no effect, whatever the other stream inputs carry. A byte with inValid and inFirst high starts a new frame at once and abandons any frame in progress. A byte arriving outside a frame without inFirst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A byte is present on inData this cycle |
| inData | input | 8 | Received byte |
| inFirst | input | 1 | This byte is the first of a frame |
| inLast | input | 1 | This byte is the last of a frame |
| inBadCrc | input | 1 | Frame has a CRC or alignment error (read with the last byte) |
| cfgAcceptBcast | input | 1 | Accept broadcast destinations |
| cfgAcceptMcast | input | 1 | Accept multicast destinations whose hash bin is set |
| cfgPromisc | input | 1 | Accept all unicast destinations |
| cfgAcceptRunt | input | 1 | Accept frames shorter than the minimum length |
| cfgSaveBad | input | 1 | Accept frames flagged with a CRC/alignment error |
| cfgMonitor | input | 1 | Check frames but flag accepted ones as missed |
| cfgAutoTx | input | 1 | Enable remote transmitter off/on through hash bins 62/63 |
| stationAddr | input | 48 | Station address, byte 0 in bits 7:0 |
| hashTable | input | 64 | Multicast hash bins, bin n in bit n |
| addrDone | output | 1 | Address verdict pulse |
| addrHit | output | 1 | Destination accepted by address rules |
| addrGroup | output | 1 | 0 for unicast, 1 for multicast or broadcast |
| frameDone | output | 1 | Frame verdict pulse |
| frameStore | output | 1 | Frame accepted for storage |
| frameMissed | output | 1 | Frame accepted but not stored (monitor mode) |
| txOff | output | 1 | Remote transmitter-disable pulse |
| txOn | output | 1 | Remote transmitter-enable pulse |

## Verification
In a frame of exactly six bytes, the address verdict and the frame verdict fall in the same cycle. The frame verdict must then use the address result being formed that cycle, not the cleared one held from the frame start. The bench provokes this with directed and random six-byte frames, mixing unicast, broadcast and hashed multicast destinations. It checks that addrDone and frameDone rise together, and that frameStore, frameMissed and addrHit agree with the bench's own address, length and error model. Frames of one to five bytes, and frames restarted mid-address, confirm that the frame verdict is a reject with no address pulse.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic clear;   // first byte of a new frame
    logic take;    // byte belongs to the current frame
    logic shift;   // byte is part of the destination address
    logic decide;  // byte completes the destination address
    logic finish;  // byte ends the frame
  } rxfStrobe_t;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  output rxfStrobe_t strobe
);

  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(ADDR_BYTES);

  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] idxEff;
  logic             inFrame;

  always_comb begin
    strobe.clear  = inValid && inFirst;
    strobe.take   = inValid && (inFirst || inFrame);
    idxEff        = strobe.clear ? '0 : byteIdx;
    strobe.shift  = strobe.take && (idxEff < END_IDX);
    strobe.decide = strobe.shift && (idxEff == LAST_IDX);
    strobe.finish = strobe.take && inLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      inFrame <= 1'b0;
    end else if (strobe.take) begin
      inFrame <= !inLast;
      if (strobe.shift) byteIdx <= idxEff + 1'b1;
    end
  end

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64,
  parameter int LEN_W      = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxfStrobe_t                strobe,
  input  logic [7:0]                inData,
  input  logic                      inBadCrc,
  input  logic                      cfgAcceptBcast,
  input  logic                      cfgAcceptMcast,
  input  logic                      cfgPromisc,
  input  logic                      cfgAcceptRunt,
  input  logic                      cfgSaveBad,
  input  logic                      cfgMonitor,
  input  logic                      cfgAutoTx,
  input  logic [8*ADDR_BYTES-1:0]   stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  output logic                      addrDone,
  output logic                      addrHit,
  output logic                      addrGroup,
  output logic                      frameDone,
  output logic                      frameStore,
  output logic                      frameMissed,
  output logic                      txOff,
  output logic                      txOn
);

  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [HASH_BITS-1:0] OFF_BIN = HASH_BITS'((1 << HASH_BITS) - 2);
  localparam logic [HASH_BITS-1:0] ON_BIN  = HASH_BITS'((1 << HASH_BITS) - 1);
  localparam logic [LEN_W-1:0]     MIN_CNT = LEN_W'(MIN_LEN);

  logic [AW-1:0]        destReg, destNext;
  logic [31:0]          crcReg, crcSeed, crcNext;
  logic [LEN_W-1:0]     lenCnt, lenNext;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 isGroup, isBcast, isUcastHit, isMcastHit, hitNow;
  logic                 hitBase, matchUse, lenOk, errOk, frameOk;
  logic                 offNow, onNow;

  // address path
  always_comb begin
    destNext   = {inData, destReg[AW-1:8]};
    crcSeed    = strobe.clear ? '1 : crcReg;
    crcNext    = crcByte(crcSeed, inData);
    hashIdx    = crcNext[31:32-HASH_BITS];
    isGroup    = destNext[0];
    isBcast    = &destNext;
    isUcastHit = cfgPromisc || (destNext == stationAddr);
    isMcastHit = cfgAcceptMcast && hashTable[hashIdx];
    if (isBcast)      hitNow = cfgAcceptBcast;
    else if (isGroup) hitNow = isMcastHit;
    else              hitNow = isUcastHit;
    offNow = cfgAutoTx && isGroup && !isBcast && (hashIdx == OFF_BIN);
    onNow  = cfgAutoTx && isGroup && !isBcast && (hashIdx == ON_BIN);
  end

  // frame path
  always_comb begin
    if (strobe.clear)  lenNext = LEN_W'(1);
    else if (&lenCnt)  lenNext = lenCnt;
    else               lenNext = lenCnt + 1'b1;
    hitBase  = strobe.clear ? 1'b0 : addrHit;
    matchUse = strobe.decide ? hitNow : hitBase;
    lenOk    = (lenNext >= MIN_CNT) || cfgAcceptRunt;
    errOk    = !inBadCrc || cfgSaveBad;
    frameOk  = matchUse && lenOk && errOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destReg <= '0;
      crcReg  <= '1;
      lenCnt  <= '0;
    end else begin
      if (strobe.shift) begin
        destReg <= destNext;
        crcReg  <= crcNext;
      end
      if (strobe.take) lenCnt <= lenNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrDone  <= 1'b0;
      addrHit   <= 1'b0;
      addrGroup <= 1'b0;
      txOff     <= 1'b0;
      txOn      <= 1'b0;
    end else begin
      addrDone <= strobe.decide;
      txOff    <= strobe.decide && offNow;
      txOn     <= strobe.decide && onNow;
      if (strobe.decide) begin
        addrHit   <= hitNow;
        addrGroup <= isGroup;
      end else if (strobe.clear) begin
        addrHit   <= 1'b0;
        addrGroup <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameDone   <= 1'b0;
      frameStore  <= 1'b0;
      frameMissed <= 1'b0;
    end else begin
      frameDone   <= strobe.finish;
      frameStore  <= strobe.finish && frameOk && !cfgMonitor;
      frameMissed <= strobe.finish && frameOk && cfgMonitor;
    end
  end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64,
  parameter int LEN_W      = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [7:0]                inData,
  input  logic                      inFirst,
  input  logic                      inLast,
  input  logic                      inBadCrc,
  input  logic                      cfgAcceptBcast,
  input  logic                      cfgAcceptMcast,
  input  logic                      cfgPromisc,
  input  logic                      cfgAcceptRunt,
  input  logic                      cfgSaveBad,
  input  logic                      cfgMonitor,
  input  logic                      cfgAutoTx,
  input  logic [8*ADDR_BYTES-1:0]   stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  output logic                      addrDone,
  output logic                      addrHit,
  output logic                      addrGroup,
  output logic                      frameDone,
  output logic                      frameStore,
  output logic                      frameMissed,
  output logic                      txOff,
  output logic                      txOn
);

  rxfStrobe_t strobe;

  rxf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .strobe(strobe)
  );

  rxf_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
    .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inBadCrc(inBadCrc), .cfgAcceptBcast(cfgAcceptBcast),
    .cfgAcceptMcast(cfgAcceptMcast), .cfgPromisc(cfgPromisc),
    .cfgAcceptRunt(cfgAcceptRunt), .cfgSaveBad(cfgSaveBad),
    .cfgMonitor(cfgMonitor), .cfgAutoTx(cfgAutoTx),
    .stationAddr(stationAddr), .hashTable(hashTable),
    .addrDone(addrDone), .addrHit(addrHit), .addrGroup(addrGroup),
    .frameDone(frameDone), .frameStore(frameStore),
    .frameMissed(frameMissed), .txOff(txOff), .txOn(txOn)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic cfgMonitor,
  input logic cfgAutoTx,
  input logic addrDone,
  input logic addrGroup,
  input logic frameDone,
  input logic frameStore,
  input logic frameMissed,
  input logic txOff,
  input logic txOn
);

  // R2
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |=> !addrDone);

  // R10
  addr_from_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |-> $past(inValid));

  // R6
  frame_from_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(inValid));

  // R8
  store_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStore || frameMissed) |-> frameDone);

  // R8
  store_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameStore && frameMissed));

  // R8
  store_mon_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStore |-> !$past(cfgMonitor));

  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txOff || txOn) |-> (addrDone && addrGroup && $past(cfgAutoTx)));

  // R9
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txOff, txOn}));

endmodule

bind eth_rx_addr_filter rxf_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .cfgMonitor(cfgMonitor),
  .cfgAutoTx(cfgAutoTx), .addrDone(addrDone), .addrGroup(addrGroup),
  .frameDone(frameDone), .frameStore(frameStore), .frameMissed(frameMissed),
  .txOff(txOff), .txOn(txOn)
);

// File: tb/sim_eth_rx_addr_filter.sv
module sim_eth_rx_addr_filter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0, inBadCrc = 1'b0;
  logic [7:0] inData = '0;
  logic cfgAcceptBcast = 0, cfgAcceptMcast = 0, cfgPromisc = 0;
  logic cfgAcceptRunt = 0, cfgSaveBad = 0, cfgMonitor = 0, cfgAutoTx = 0;
  logic [47:0] stationAddr = 48'h5A4B3C2D1E02;
  logic [63:0] hashTable = 64'h0;
  logic addrDone, addrHit, addrGroup, frameDone, frameStore, frameMissed, txOff, txOn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit pendAddr = 0, pendFrame = 0;
  bit eHit, eGrp, eOff, eOn, eStore, eMiss;
  string aTag, fTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_addr_filter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inFirst(inFirst), .inLast(inLast), .inBadCrc(inBadCrc),
    .cfgAcceptBcast(cfgAcceptBcast), .cfgAcceptMcast(cfgAcceptMcast),
    .cfgPromisc(cfgPromisc), .cfgAcceptRunt(cfgAcceptRunt),
    .cfgSaveBad(cfgSaveBad), .cfgMonitor(cfgMonitor), .cfgAutoTx(cfgAutoTx),
    .stationAddr(stationAddr), .hashTable(hashTable),
    .addrDone(addrDone), .addrHit(addrHit), .addrGroup(addrGroup),
    .frameDone(frameDone), .frameStore(frameStore), .frameMissed(frameMissed),
    .txOff(txOff), .txOn(txOn)
  );

  // hash index over the 48 destination bits, bit k of dest sent k-th
  function automatic int hashOf(input logic [47:0] dest);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (r[0] != dest[k]) r = (r >> 1) ^ 32'hEDB88320;
      else                 r = r >> 1;
    end
    return int'(r[31:26]);
  endfunction

  function automatic bit isBc(input logic [47:0] d); return d == {48{1'b1}}; endfunction

  function automatic bit expHit(input logic [47:0] d);
    if (isBc(d)) return cfgAcceptBcast;
    if (d[0]) return cfgAcceptMcast && hashTable[hashOf(d)];
    return cfgPromisc || (d == stationAddr);
  endfunction

  function automatic string tagOf(input logic [47:0] d);
    if (isBc(d)) return "R4";
    if (d[0]) return (cfgAutoTx && hashOf(d) >= 62) ? "R9" : "R5";
    return cfgPromisc ? "R3" : "R2";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pendAddr) begin
      check({addrDone, addrHit, addrGroup, txOff, txOn} == {1'b1, eHit, eGrp, eOff, eOn},
            aTag, "addr{done,hit,grp,off,on}",
            {3'b0, addrDone, addrHit, addrGroup, txOff, txOn},
            {3'b0, 1'b1, eHit, eGrp, eOff, eOn});
    end else if (addrDone || txOff || txOn) begin
      check(1'b0, "R10", "unexpected addr pulse", {5'b0, addrDone, txOff, txOn}, 8'h0);
    end
    if (pendFrame) begin
      check({frameDone, frameStore, frameMissed, addrHit} == {1'b1, eStore, eMiss, eHit},
            fTag, "frame{done,store,miss,hit}",
            {4'b0, frameDone, frameStore, frameMissed, addrHit},
            {4'b0, 1'b1, eStore, eMiss, eHit});
    end else if (frameDone || frameStore || frameMissed) begin
      check(1'b0, "R10", "unexpected frame pulse", {5'b0, frameDone, frameStore, frameMissed}, 8'h0);
    end
    pendAddr = 0;
    pendFrame = 0;
  endtask

  task automatic idle();
    inValid = 0; inFirst = 0; inLast = 0;
  endtask

  // gap cycle: inValid low, other stream inputs noisy (R10)
  task automatic gap();
    tick();
    inValid = 0;
    inFirst = 1'($urandom);
    inLast  = 1'($urandom);
    inData  = 8'($urandom);
    inBadCrc = 1'($urandom);
  endtask

  task automatic sendFrame(input logic [47:0] dest, input int len, input bit bad,
                           input bit gaps, input string ftag);
    bit hit = (len >= 6) && expHit(dest);
    bit acc = hit && (len >= 64 || cfgAcceptRunt) && (!bad || cfgSaveBad);
    string t = tagOf(dest);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 4) == 0) gap();
      tick();
      inValid  = 1;
      inFirst  = (i == 0);
      inLast   = (i == len - 1);
      inBadCrc = (i == len - 1) ? bad : 1'($urandom);
      inData   = (i < 6) ? dest[8*i +: 8] : 8'($urandom);
      if (i == 5) begin
        pendAddr = 1;
        eHit = hit; eGrp = dest[0];
        eOff = cfgAutoTx && dest[0] && !isBc(dest) && hashOf(dest) == 62;
        eOn  = cfgAutoTx && dest[0] && !isBc(dest) && hashOf(dest) == 63;
        aTag = t;
      end
      if (i == len - 1) begin
        pendFrame = 1;
        eHit = hit;
        eStore = acc && !cfgMonitor;
        eMiss  = acc && cfgMonitor;
        fTag = (ftag != "") ? ftag : t;
      end
    end
    tick();
    idle();
  endtask

  function automatic logic [47:0] mcastWithBin(input int bin);
    logic [47:0] d;
    do begin
      d = {16'($urandom), 32'($urandom)};
      d[0] = 1'b1;
    end while (isBc(d) || hashOf(d) != bin);
    return d;
  endfunction

  function automatic logic [47:0] pickDest();
    logic [47:0] d;
    case ($urandom % 6)
      0, 1: d = stationAddr;
      2: begin d = stationAddr; d[8*($urandom % 6) + 1 +: 1] ^= 1'b1; end
      3: d = {48{1'b1}};
      4: begin d = {16'($urandom), 32'($urandom)}; d[0] = 1'b1; end
      default: d = mcastWithBin(62 + int'($urandom % 2));
    endcase
    return d;
  endfunction

  function automatic int pickLen();
    case ($urandom % 5)
      0: return 1 + int'($urandom % 5);
      1: return 6;
      2: return 63 + int'($urandom % 2);
      default: return 60 + int'($urandom % 20);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    check({addrDone, addrHit, addrGroup, frameDone, frameStore, frameMissed, txOff, txOn} == 8'h0,
          "R1", "reset outputs",
          {addrDone, addrHit, addrGroup, frameDone, frameStore, frameMissed, txOff, txOn}, 8'h0);
    rstN = 1;
    tick();
    hashTable = {$urandom, $urandom};

    // R2 exact and mismatched unicast
    sendFrame(stationAddr, 64, 0, 0, "R2");
    sendFrame(stationAddr ^ 48'h0100_0000_0000, 64, 0, 0, "R2");
    // R3 promiscuous
    cfgPromisc = 1;
    sendFrame(48'h0011_2233_4454, 70, 0, 0, "R3");
    cfgPromisc = 0;
    // R4 broadcast both settings
    sendFrame({48{1'b1}}, 64, 0, 0, "R4");
    cfgAcceptBcast = 1;
    sendFrame({48{1'b1}}, 64, 0, 0, "R4");
    // R5 multicast, bin set and clear
    cfgAcceptMcast = 1;
    hashTable[10] = 1; hashTable[11] = 0;
    sendFrame(mcastWithBin(10), 64, 0, 0, "R5");
    sendFrame(mcastWithBin(11), 64, 0, 0, "R5");
    cfgAcceptMcast = 0;
    sendFrame(mcastWithBin(10), 64, 0, 0, "R5");
    // R6 runt boundary
    sendFrame(stationAddr, 63, 0, 0, "R6");
    cfgAcceptRunt = 1;
    sendFrame(stationAddr, 6, 0, 0, "R6");
    sendFrame(stationAddr, 5, 0, 0, "R6");
    cfgAcceptRunt = 0;
    // R7 errored
    sendFrame(stationAddr, 64, 1, 0, "R7");
    cfgSaveBad = 1;
    sendFrame(stationAddr, 64, 1, 0, "R7");
    cfgSaveBad = 0;
    // R8 monitor
    cfgMonitor = 1;
    sendFrame(stationAddr, 64, 0, 0, "R8");
    cfgMonitor = 0;
    // R9 remote transmitter bins, ignoring mcast accept and table
    cfgAutoTx = 1;
    sendFrame(mcastWithBin(62), 64, 0, 0, "R9");
    sendFrame(mcastWithBin(63), 64, 0, 0, "R9");
    cfgAutoTx = 0;
    sendFrame(mcastWithBin(62), 64, 0, 0, "R9");
    // R10 gaps, stray byte outside frame, and mid-address restart
    sendFrame(stationAddr, 64, 0, 1, "R10");
    tick(); inValid = 1; inFirst = 0; inLast = 1; inData = 8'h55;
    tick(); idle();
    for (int i = 0; i < 3; i++) begin
      tick(); inValid = 1; inFirst = (i == 0); inLast = 0; inData = stationAddr[8*i +: 8];
    end
    sendFrame(stationAddr, 6, 0, 0, "R10");

    // random mix
    for (int n = 0; n < 300; n++) begin
      cfgAcceptBcast = 1'($urandom); cfgAcceptMcast = 1'($urandom);
      cfgPromisc = (($urandom % 4) == 0); cfgAcceptRunt = 1'($urandom);
      cfgSaveBad = 1'($urandom); cfgMonitor = (($urandom % 4) == 0);
      cfgAutoTx = 1'($urandom);
      if (($urandom % 8) == 0) hashTable = {$urandom, $urandom};
      sendFrame(pickDest(), pickLen(), (($urandom % 4) == 0), 1'($urandom), "");
    end

    tick();
    tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule